// File: doc/BRIEF.md
# Interrupt Event Aggregator

This block keeps a word of sticky event flags and a matching word of enable bits, and it turns them into three level interrupt lines: one for transmit, one for receive and one for errors. Hardware sources elsewhere in the controller pulse bits on a set vector. Each pulsed bit is latched in the event word. Software acknowledges events by writing a word in which every one bit clears the matching flag and every zero bit leaves its flag alone.

Every event bit belongs to at most one of three groups. A line goes high when a bit of its group is set while that bit's enable is on. It stays high until a clear write leaves no bit of its group set. The error group is wide, so the error line is only released once software has acknowledged every pending error-class flag. Among these flags are the two graceful stop completion events. Bits that belong to no group are latched and can be read back, but they never drive a line.

Each line is driven by a two-state machine. The states are `LINE_QUIET` (line low) and `LINE_RAISED` (line high). The machine has two transitions: `QUIET->RAISED` on an enabled set in its group, and `RAISED->QUIET` on a clear write that leaves its group empty, provided no enabled set arrives in the same cycle.

Top module: `irqagg_top`

## Requirements
- R1: While reset is asserted and after it is released, the event word, the enable word and all three lines are zero.
- R2: A bit pulsed on `evt_set_i` is one in `evt_o` from the next clock edge on, until it is cleared.
- R3: A clear write (`clr_we_i` high) zeroes each event bit whose `clr_data_i` bit is one. Bits whose `clr_data_i` bit is zero keep their value.
- R4: When a bit is set and cleared in the same cycle, it is one afterwards.
- R5: A mask write (`msk_we_i` high) loads `msk_data_i` into the enable word, and the new value appears on `msk_o` after the edge.
- R6: A set of an event bit whose enable bit is one raises its group's line at the next edge. A set of a bit whose enable bit is zero does not raise the line.
- R7: A raised line stays high while any bit of its group is set. It goes low at the edge of a clear write that leaves its group with no bit set. A clear that empties other groups does not affect it.
- R8: Group layout: bit 0 is the transmit-frame event (transmit line), and bit 1 is the receive-frame event (receive line). Bits 4 to 23 form the error group: magic packet, graceful transmit stop done (bit 5), graceful receive stop done (bit 6), transmit and receive control, babbling receive and transmit, late collision, retry limit, three filer events, data and parity errors, bus error, transmit error, underrun, busy, and MII read and write completion.
- R9: A set of graceful transmit stop done (bit 5) or graceful receive stop done (bit 6) with its enable on raises the error line.
- R10: When one cycle brings both an enabled set in a group and a clear that would empty that group, the line is high afterwards.
- R11: Bits 2, 3 and 24 to 31 belong to no group and never raise any line.
- R12: Turning on an enable bit for an event that is already pending does not raise a line. Only a set raises a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | EVT_W | One-cycle set pulses from event sources |
| clr_we_i | input | 1 | Clear write strobe |
| clr_data_i | input | EVT_W | Clear write data, ones clear |
| msk_we_i | input | 1 | Enable word write strobe |
| msk_data_i | input | EVT_W | Enable word write data |
| evt_o | output | EVT_W | Current event word |
| msk_o | output | EVT_W | Current enable word |
| irq_tx_o | output | 1 | Transmit interrupt level |
| irq_rx_o | output | 1 | Receive interrupt level |
| irq_err_o | output | 1 | Error interrupt level |

## Verification
The bench builds the block with its default parameters: a 32-bit event word, one-bit transmit and receive groups, a twenty-bit error group, and ten bits outside every group. This layout lets the bench hold the error line with one flag while it acknowledges another. It can also show that the single-bit groups drop as soon as their only flag is cleared, and that the ungrouped bits latch without any line moving. The default masks place both graceful stop flags in the error group, so the stop-completion rule is reached directly.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int EVT_W_DEF = 32;

    // event bit positions
    localparam int B_TX_FRAME   = 0;
    localparam int B_RX_FRAME   = 1;
    localparam int B_GTS_DONE   = 5;
    localparam int B_GRS_DONE   = 6;

    localparam logic [EVT_W_DEF-1:0] GRP_TX_DEF  = 32'h0000_0001;
    localparam logic [EVT_W_DEF-1:0] GRP_RX_DEF  = 32'h0000_0002;
    localparam logic [EVT_W_DEF-1:0] GRP_ERR_DEF = 32'h00FF_FFF0;

    localparam int N_LINES = 3;
    localparam int L_TX  = 0;
    localparam int L_RX  = 1;
    localparam int L_ERR = 2;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/irqagg_event_reg.sv
module irqagg_event_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] nxt_o,
    output logic [W-1:0] q_o
);
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we_i ? clr_data_i : '0;
        // set has priority over a clear of the same bit
        nxt_o   = (q_o & ~clr_eff) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt_o;
    end
endmodule

// File: rtl/irqagg_mask_reg.sv
module irqagg_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_o <= '0;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/irqagg_line_fsm.sv
module irqagg_line_fsm
    import irqagg_pkg::*;
#(
    parameter int         W   = 32,
    parameter logic [W-1:0] GRP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] msk_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] evt_nxt_i,
    output logic         irq_o
);
    line_state_e state_q, state_d;
    logic grp_set, grp_empty;

    always_comb begin
        grp_set   = |(set_i & msk_i & GRP);
        grp_empty = ~|(evt_nxt_i & GRP);
        state_d   = state_q;
        unique case (state_q)
            LINE_QUIET:  if (grp_set) state_d = LINE_RAISED;
            LINE_RAISED: if (!grp_set && clr_we_i && grp_empty) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int             EVT_W   = EVT_W_DEF,
    parameter logic [EVT_W-1:0] GRP_TX  = GRP_TX_DEF,
    parameter logic [EVT_W-1:0] GRP_RX  = GRP_RX_DEF,
    parameter logic [EVT_W-1:0] GRP_ERR = GRP_ERR_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_set_i,
    input  logic             clr_we_i,
    input  logic [EVT_W-1:0] clr_data_i,
    input  logic             msk_we_i,
    input  logic [EVT_W-1:0] msk_data_i,
    output logic [EVT_W-1:0] evt_o,
    output logic [EVT_W-1:0] msk_o,
    output logic             irq_tx_o,
    output logic             irq_rx_o,
    output logic             irq_err_o
);
    localparam logic [N_LINES-1:0][EVT_W-1:0] GRPS = {GRP_ERR, GRP_RX, GRP_TX};

    logic [EVT_W-1:0]   evt_nxt;
    logic [N_LINES-1:0] irq_vec;

    irqagg_event_reg #(.W(EVT_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(evt_set_i),
        .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
        .nxt_o(evt_nxt), .q_o(evt_o)
    );

    irqagg_mask_reg #(.W(EVT_W)) u_msk (
        .clk(clk), .rst_n(rst_n), .we_i(msk_we_i), .d_i(msk_data_i), .q_o(msk_o)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irqagg_line_fsm #(.W(EVT_W), .GRP(GRPS[g])) u_fsm (
            .clk(clk), .rst_n(rst_n), .set_i(evt_set_i), .msk_i(msk_o),
            .clr_we_i(clr_we_i), .evt_nxt_i(evt_nxt), .irq_o(irq_vec[g])
        );
    end

    assign irq_tx_o  = irq_vec[L_TX];
    assign irq_rx_o  = irq_vec[L_RX];
    assign irq_err_o = irq_vec[L_ERR];
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int             EVT_W   = 32,
    parameter logic [EVT_W-1:0] GRP_TX  = '0,
    parameter logic [EVT_W-1:0] GRP_RX  = '0,
    parameter logic [EVT_W-1:0] GRP_ERR = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EVT_W-1:0] evt_set_i,
    input logic             clr_we_i,
    input logic [EVT_W-1:0] clr_data_i,
    input logic [EVT_W-1:0] evt_o,
    input logic [EVT_W-1:0] msk_o,
    input logic             irq_tx_o,
    input logic             irq_rx_o,
    input logic             irq_err_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (evt_o == '0 && !irq_tx_o && !irq_rx_o && !irq_err_o));

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set_i != '0) |=> ((evt_o & $past(evt_set_i)) == $past(evt_set_i)));

    p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((evt_o & $past(clr_data_i & ~evt_set_i)) == '0));

    p_tx_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set_i & msk_o & GRP_TX) != '0) |=> irq_tx_o);

    p_err_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set_i & msk_o & GRP_ERR) != '0) |=> irq_err_o);

    p_err_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_err_o) |-> ($past(clr_we_i) && ((evt_o & GRP_ERR) == '0)));

    p_tx_has_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_o |-> ((evt_o & GRP_TX) != '0));

    p_rx_has_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_o |-> ((evt_o & GRP_RX) != '0));
endmodule

bind irqagg_top irqagg_chk #(
    .EVT_W(EVT_W), .GRP_TX(GRP_TX), .GRP_RX(GRP_RX), .GRP_ERR(GRP_ERR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i), .clr_we_i(clr_we_i),
    .clr_data_i(clr_data_i), .evt_o(evt_o), .msk_o(msk_o),
    .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o)
);

// File: tb/sim_irqagg_top.sv
module sim_irqagg_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_set = '0;
    logic         clr_we = 1'b0;
    logic [W-1:0] clr_data = '0;
    logic         msk_we = 1'b0;
    logic [W-1:0] msk_data = '0;
    logic [W-1:0] evt, msk;
    logic         irq_tx, irq_rx, irq_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top u0 (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .clr_we_i(clr_we),
        .clr_data_i(clr_data), .msk_we_i(msk_we), .msk_data_i(msk_data),
        .evt_o(evt), .msk_o(msk), .irq_tx_o(irq_tx), .irq_rx_o(irq_rx),
        .irq_err_o(irq_err)
    );

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(string req, logic [W-1:0] e_evt, logic [2:0] e_irq);
        chk(req, "evt", evt, e_evt);
        chk(req, "irq{err,rx,tx}", {29'd0, irq_err, irq_rx, irq_tx}, {29'd0, e_irq});
    endtask

    // one cycle of stimulus, returns after the edge when outputs settled
    task automatic cyc(logic [W-1:0] s, logic cw, logic [W-1:0] cd, logic mw, logic [W-1:0] md);
        @(negedge clk);
        evt_set = s; clr_we = cw; clr_data = cd; msk_we = mw; msk_data = md;
        @(negedge clk);
        evt_set = '0; clr_we = 1'b0; clr_data = '0; msk_we = 1'b0; msk_data = '0;
    endtask

    task automatic t_reset();   // R1
        chk_state("R1", '0, 3'b000);
        chk("R1", "msk", msk, '0);
    endtask

    task automatic t_mask();    // R5
        cyc('0, 0, '0, 1, 32'hFFFF_FFFF);
        chk("R5", "msk", msk, 32'hFFFF_FFFF);
    endtask

    task automatic t_tx();      // R2 R3 R6 R7 R8
        cyc(32'h1, 0, '0, 0, '0);
        chk_state("R6", 32'h1, 3'b001);
        cyc('0, 1, 32'h2, 0, '0);
        chk_state("R3", 32'h1, 3'b001);
        cyc('0, 1, 32'h1, 0, '0);
        chk_state("R7", 32'h0, 3'b000);
    endtask

    task automatic t_rx();      // R8
        cyc(32'h2, 0, '0, 0, '0);
        chk_state("R8", 32'h2, 3'b010);
        cyc('0, 1, 32'h2, 0, '0);
        chk_state("R8", 32'h0, 3'b000);
    endtask

    task automatic t_graceful();  // R9 R7
        cyc(32'h20, 0, '0, 0, '0);
        chk_state("R9", 32'h20, 3'b100);
        cyc(32'h40, 0, '0, 0, '0);
        chk_state("R9", 32'h60, 3'b100);
        cyc('0, 1, 32'h20, 0, '0);
        chk_state("R7", 32'h40, 3'b100);
        cyc('0, 1, 32'h40, 0, '0);
        chk_state("R7", 32'h0, 3'b000);
    endtask

    task automatic t_collide();   // R4 R10
        cyc(32'h1, 1, 32'h1, 0, '0);
        chk_state("R4", 32'h1, 3'b001);
        cyc(32'h1, 1, 32'h1, 0, '0);
        chk_state("R10", 32'h1, 3'b001);
        cyc('0, 1, 32'h1, 0, '0);
        chk_state("R4", 32'h0, 3'b000);
    endtask

    task automatic t_ungrouped(); // R11
        cyc(32'h8000_000C, 0, '0, 0, '0);
        chk_state("R11", 32'h8000_000C, 3'b000);
        cyc(32'h0F00_0000, 0, '0, 0, '0);
        chk_state("R11", 32'h8F00_000C, 3'b000);
        cyc('0, 1, 32'hFFFF_FFFF, 0, '0);
        chk_state("R3", 32'h0, 3'b000);
    endtask

    task automatic t_disabled();  // R6 R7 R12
        cyc('0, 0, '0, 1, 32'hFFFF_FFDF);
        cyc(32'h20, 0, '0, 0, '0);
        chk_state("R6", 32'h20, 3'b000);
        cyc('0, 0, '0, 1, 32'hFFFF_FFFF);
        chk_state("R12", 32'h20, 3'b000);
        cyc(32'h400, 0, '0, 0, '0);
        chk_state("R6", 32'h420, 3'b100);
        cyc('0, 1, 32'h400, 0, '0);
        chk_state("R7", 32'h20, 3'b100);
        cyc('0, 1, 32'h20, 0, '0);
        chk_state("R7", 32'h0, 3'b000);
    endtask

    task automatic t_cross();     // R7 across groups
        cyc(32'h1, 0, '0, 0, '0);
        cyc(32'h2, 1, 32'h1, 0, '0);
        chk_state("R7", 32'h2, 3'b010);
        cyc(32'h00FF_FFF0, 1, 32'h2, 0, '0);
        chk_state("R8", 32'h00FF_FFF0, 3'b100);
        cyc('0, 1, 32'h007F_FFF0, 0, '0);
        chk_state("R7", 32'h0080_0000, 3'b100);
        cyc('0, 1, 32'h0080_0000, 0, '0);
        chk_state("R7", 32'h0, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_tx();
        t_rx();
        t_graceful();
        t_collide();
        t_ungrouped();
        t_disabled();
        t_cross();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule